// File: doc/BRIEF.md
# Interrupt Entry Controller with Shared Return Stack

This block decides when a pending interrupt is taken. It runs the entry and return sequence, and it keeps the return-address stack that subroutine calls also use. Four sources each present a pending flag and an individual enable. The block owns the global interrupt enable bit. The instruction path signals calls, plain returns and interrupt returns with single-cycle strobes, and it supplies the current program counter. The block answers with a one-cycle program-counter load request and the address to load.

When an interrupt is taken, the global enable is cleared, the current program counter is pushed and the fixed vector 0x004 is loaded, all at the same clock edge. The interrupt return pops the saved address and sets the global enable again. The block never clears a source flag. A source that is still pending after the return is taken again as soon as the enable allows it.

The stack is a fixed 8-entry LIFO with a wrapping pointer. A ninth push overwrites the oldest entry and raises no error.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset the global enable output is 0, the load request is 0 and the load address is 0x000. A plain return issued at once loads 0x000.
- R2: An interrupt is taken when all three of these hold: the global enable is 1, at least one source has both its flag and its enable at 1, and no call, return or interrupt-return strobe is active. In the cycle after it is taken, the load request is 1 and the load address is 0x004.
- R3: Taking an interrupt clears the global enable at the same edge and pushes the current program counter. A later interrupt return loads that value again.
- R4: No interrupt is taken while the global enable is 0. No interrupt is taken when every source that has its flag set has its enable at 0.
- R5: An interrupt return pops the top entry. One cycle later it raises the load request with that address and sets the global enable to 1.
- R6: A call pushes the current program counter and loads the call target. A plain return pops the top entry into the load address and leaves the global enable unchanged.
- R7: Nested calls and interrupts return in last-in, first-out order.
- R8: The stack holds 8 entries and its pointer wraps. After nine pushes of A0..A8, nine pops return A8, A7, ..., A1 and then A8 again.
- R9: The strobes have a fixed priority: interrupt return first, then plain return, then call. Any strobe defers a pending interrupt, and the interrupt is taken in the first cycle with no strobe.
- R10: A global-enable write sets the enable to the written value one cycle later. An interrupt taken in the same cycle overrides the write, and so does an interrupt return.
- R11: Source flags are never cleared by the block. A source still pending after an interrupt return is taken again in the next strobe-free cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_flag | input | 4 | Pending flag of each source |
| src_en | input | 4 | Individual enable of each source |
| gie_wr | input | 1 | Software write strobe for the global enable |
| gie_wdata | input | 1 | Value written to the global enable |
| call_stb | input | 1 | Subroutine call strobe |
| ret_stb | input | 1 | Plain return strobe |
| reti_stb | input | 1 | Return-from-interrupt strobe |
| call_tgt | input | 13 | Target address of a call |
| pc_i | input | 13 | Current program counter |
| pc_load_o | output | 1 | One-cycle program-counter load request |
| pc_addr_o | output | 13 | Address to load |
| gie_o | output | 1 | Global interrupt enable |

## Verification
Every result of this block is registered exactly once. An accepted interrupt, a call, a return or an enable write shows at the outputs one clock edge after the cycle in which its inputs were presented. The bench drives inputs shortly after a rising edge and samples the outputs shortly after the next rising edge, so each check falls in the single cycle that holds the result. A deferred interrupt is checked in two steps: first the cycle in which a strobe is present and no entry happens, then the first strobe-free cycle, in which the entry appears.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    typedef enum logic [2:0] {
        OP_NONE,
        OP_IRQ,
        OP_CALL,
        OP_RET,
        OP_RETI
    } irq_op_e;
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
    parameter int NSRC = 4
) (
    input  logic [NSRC-1:0] flag,
    input  logic [NSRC-1:0] en,
    input  logic            gie,
    output logic            req
);
    logic [NSRC-1:0] live;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign live[i] = flag[i] & en[i];
    end

    assign req = gie & (|live);
endmodule

// File: rtl/irq_op_sel.sv
module irq_op_sel
    import irq_entry_pkg::*;
(
    input  logic    req,
    input  logic    call_stb,
    input  logic    ret_stb,
    input  logic    reti_stb,
    output irq_op_e op
);
    always_comb begin
        if (reti_stb)      op = OP_RETI;
        else if (ret_stb)  op = OP_RET;
        else if (call_stb) op = OP_CALL;
        else if (req)      op = OP_IRQ;
        else               op = OP_NONE;
    end
endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack #(
    parameter int W     = 13,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PW-1:0]           ptr;
        logic [DEPTH-1:0][W-1:0] mem;
    } stk_t;

    stk_t cur_q, nxt_d;
    logic [PW-1:0] top_idx;

    assign top_idx = cur_q.ptr - PW'(1);
    assign top     = cur_q.mem[top_idx];

    always_comb begin
        nxt_d = cur_q;
        if (pop) begin
            nxt_d.ptr = top_idx;
        end else if (push) begin
            nxt_d.mem[cur_q.ptr] = din;
            nxt_d.ptr            = cur_q.ptr + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int PC_W     = 13,
    parameter int DEPTH    = 8,
    parameter int NSRC     = 4,
    parameter int VEC_ADDR = 4,
    parameter int RST_ADDR = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_flag,
    input  logic [NSRC-1:0] src_en,
    input  logic            gie_wr,
    input  logic            gie_wdata,
    input  logic            call_stb,
    input  logic            ret_stb,
    input  logic            reti_stb,
    input  logic [PC_W-1:0] call_tgt,
    input  logic [PC_W-1:0] pc_i,
    output logic            pc_load_o,
    output logic [PC_W-1:0] pc_addr_o,
    output logic            gie_o
);
    localparam logic [PC_W-1:0] VEC = PC_W'(VEC_ADDR);
    localparam logic [PC_W-1:0] RST = PC_W'(RST_ADDR);

    typedef struct packed {
        logic            gie;
        logic            load;
        logic [PC_W-1:0] addr;
    } ctl_t;

    ctl_t          ctl_q, ctl_d;
    logic          req;
    irq_op_e       op;
    logic          push, pop;
    logic [PC_W-1:0] push_val, top;

    irq_qualify #(.NSRC(NSRC)) u_qual (
        .flag (src_flag),
        .en   (src_en),
        .gie  (ctl_q.gie),
        .req  (req)
    );

    irq_op_sel u_sel (
        .req      (req),
        .call_stb (call_stb),
        .ret_stb  (ret_stb),
        .reti_stb (reti_stb),
        .op       (op)
    );

    irq_ret_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (push_val),
        .top   (top)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.load = 1'b0;
        push       = 1'b0;
        pop        = 1'b0;
        push_val   = pc_i;
        if (gie_wr) ctl_d.gie = gie_wdata;
        case (op)
            OP_IRQ: begin
                ctl_d.gie  = 1'b0;
                ctl_d.load = 1'b1;
                ctl_d.addr = VEC;
                push       = 1'b1;
            end
            OP_CALL: begin
                ctl_d.load = 1'b1;
                ctl_d.addr = call_tgt;
                push       = 1'b1;
            end
            OP_RET: begin
                ctl_d.load = 1'b1;
                ctl_d.addr = top;
                pop        = 1'b1;
            end
            OP_RETI: begin
                ctl_d.gie  = 1'b1;
                ctl_d.load = 1'b1;
                ctl_d.addr = top;
                pop        = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.gie  <= 1'b0;
            ctl_q.load <= 1'b0;
            ctl_q.addr <= RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pc_load_o = ctl_q.load;
    assign pc_addr_o = ctl_q.addr;
    assign gie_o     = ctl_q.gie;
endmodule

// File: rtl/irq_entry_ctrl_chk.sv
module irq_entry_ctrl_chk #(
    parameter int PC_W     = 13,
    parameter int NSRC     = 4,
    parameter int VEC_ADDR = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_flag,
    input logic [NSRC-1:0] src_en,
    input logic            gie_wr,
    input logic            call_stb,
    input logic            ret_stb,
    input logic            reti_stb,
    input logic [PC_W-1:0] call_tgt,
    input logic            pc_load_o,
    input logic [PC_W-1:0] pc_addr_o,
    input logic            gie_o
);
    logic any_stb, take;
    assign any_stb = call_stb | ret_stb | reti_stb;
    assign take    = gie_o && (|(src_flag & src_en)) && !any_stb;

    AST_ENTRY_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> pc_load_o && pc_addr_o == PC_W'(VEC_ADDR)); // R2

    AST_ENTRY_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !gie_o); // R3

    AST_RETI_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        reti_stb |=> gie_o && pc_load_o); // R5

    AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (call_stb && !ret_stb && !reti_stb) |=> pc_load_o && pc_addr_o == $past(call_tgt)); // R6

    AST_NO_SPURIOUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_stb && !take) |=> !pc_load_o); // R4

    AST_GIE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie_wr && !reti_stb && !take) |=> $stable(gie_o)); // R10
endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk #(
    .PC_W(PC_W), .NSRC(NSRC), .VEC_ADDR(VEC_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
    .gie_wr(gie_wr), .call_stb(call_stb), .ret_stb(ret_stb),
    .reti_stb(reti_stb), .call_tgt(call_tgt), .pc_load_o(pc_load_o),
    .pc_addr_o(pc_addr_o), .gie_o(gie_o)
);

// File: tb/irq_entry_ctrl_tb_top.sv
module irq_entry_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_flag = '0, src_en = '0;
    logic        gie_wr = 1'b0, gie_wdata = 1'b0;
    logic        call_stb = 1'b0, ret_stb = 1'b0, reti_stb = 1'b0;
    logic [12:0] call_tgt = '0, pc_i = '0;
    logic        pc_load_o, gie_o;
    logic [12:0] pc_addr_o;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    irq_entry_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
        .gie_wr(gie_wr), .gie_wdata(gie_wdata), .call_stb(call_stb),
        .ret_stb(ret_stb), .reti_stb(reti_stb), .call_tgt(call_tgt),
        .pc_i(pc_i), .pc_load_o(pc_load_o), .pc_addr_o(pc_addr_o),
        .gie_o(gie_o)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic idle();
        call_stb = 0; ret_stb = 0; reti_stb = 0; gie_wr = 0;
    endtask

    task automatic t_reset();
        chk("R1", "gie", gie_o, 0);
        chk("R1", "load", pc_load_o, 0);
        chk("R1", "addr", pc_addr_o, 0);
        ret_stb = 1; tick(); idle();
        chk("R1", "ret load", pc_load_o, 1);
        chk("R1", "ret addr", pc_addr_o, 0);
        tick();
    endtask

    task automatic t_gate();
        src_flag = 4'b0001; src_en = 4'b0001; tick();
        chk("R4", "no entry gie0", pc_load_o, 0);
        src_flag = 4'b0010; gie_wr = 1; gie_wdata = 1; tick(); idle();
        chk("R10", "gie written", gie_o, 1);
        chk("R4", "no entry masked", pc_load_o, 0);
        tick();
        chk("R4", "still no entry", pc_load_o, 0);
        src_flag = 0; src_en = 0;
    endtask

    task automatic t_entry();
        pc_i = 13'h123; src_en = 4'b0011; src_flag = 4'b0010; tick();
        src_flag = 0;
        chk("R2", "entry load", pc_load_o, 1);
        chk("R2", "entry addr", pc_addr_o, 13'h004);
        chk("R3", "gie cleared", gie_o, 0);
        pc_i = 13'h004; tick();
        chk("R2", "load one cycle", pc_load_o, 0);
        reti_stb = 1; tick(); idle();
        chk("R5", "reti load", pc_load_o, 1);
        chk("R3", "reti addr", pc_addr_o, 13'h123);
        chk("R5", "reti gie", gie_o, 1);
        tick();
    endtask

    task automatic t_reentry();
        pc_i = 13'h050; src_en = 4'b0100; src_flag = 4'b0100; tick();
        chk("R11", "first entry", pc_addr_o, 13'h004);
        reti_stb = 1; tick(); idle();
        chk("R11", "return addr", pc_addr_o, 13'h050);
        chk("R11", "return gie", gie_o, 1);
        tick();
        chk("R11", "re-entry load", pc_load_o, 1);
        chk("R11", "re-entry gie", gie_o, 0);
        src_flag = 0; reti_stb = 1; tick(); idle();
        chk("R11", "second return", pc_addr_o, 13'h050);
        tick();
    endtask

    task automatic t_nest();
        src_en = 4'b1000; src_flag = 4'b1000; pc_i = 13'h200; tick();
        src_flag = 0;
        chk("R7", "isr entry", pc_addr_o, 13'h004);
        pc_i = 13'h010; call_tgt = 13'h300; call_stb = 1; tick(); idle();
        chk("R6", "call target", pc_addr_o, 13'h300);
        ret_stb = 1; tick(); idle();
        chk("R6", "ret addr", pc_addr_o, 13'h010);
        chk("R6", "ret keeps gie", gie_o, 0);
        reti_stb = 1; tick(); idle();
        chk("R7", "outer return", pc_addr_o, 13'h200);
        chk("R7", "outer gie", gie_o, 1);
        tick();
    endtask

    task automatic t_prio();
        src_en = 4'b0001; src_flag = 4'b0001;
        pc_i = 13'h0AA; call_tgt = 13'h111; call_stb = 1; tick(); idle();
        chk("R9", "call beats irq", pc_addr_o, 13'h111);
        chk("R9", "irq deferred gie", gie_o, 1);
        pc_i = 13'h0BB; call_tgt = 13'h222; call_stb = 1; ret_stb = 1; tick(); idle();
        chk("R9", "ret beats call", pc_addr_o, 13'h0AA);
        chk("R9", "still deferred", gie_o, 1);
        pc_i = 13'h0CC; gie_wr = 1; gie_wdata = 1; tick(); idle();
        chk("R9", "entry after strobes", pc_addr_o, 13'h004);
        chk("R10", "entry beats write", gie_o, 0);
        src_flag = 0; reti_stb = 1; gie_wr = 1; gie_wdata = 0; tick(); idle();
        chk("R9", "return to deferred pc", pc_addr_o, 13'h0CC);
        chk("R10", "reti beats write", gie_o, 1);
        gie_wr = 1; gie_wdata = 0; tick(); idle();
        chk("R10", "gie cleared by write", gie_o, 0);
    endtask

    task automatic t_overflow();
        src_en = 0;
        for (int k = 0; k < 9; k++) begin
            pc_i = 13'h400 + 13'(k); call_tgt = 13'h700; call_stb = 1; tick();
        end
        idle(); call_stb = 0;
        for (int k = 0; k < 9; k++) begin
            ret_stb = 1; tick();
            chk("R8", "wrapped pop", pc_addr_o, (k == 8) ? 13'h408 : 13'h408 - 13'(k));
        end
        idle(); tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        #1;
        t_reset();
        t_gate();
        t_entry();
        t_reentry();
        t_nest();
        t_prio();
        t_overflow();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule